// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a digitized video stream one sample per clock and finds the vertical sync interval. It measures how long the signal sits low after each line start. A per-line low-sample counter is compared against a programmable threshold. The first crossing raises the vertical sync output at once. At the same moment the block decides whether the field that begins is odd or even, from where in the line the crossing fell.

When no sync is found, a line counter keeps the outputs running. It produces synthetic vertical sync pulses and field toggles at the nominal field length of the selected standard: 262/263 lines for 525-line video and 312/313 for 625-line video. A separate miss counter tracks the lines that pass with no crossing. When that count reaches the loss limit, the block emits a one-clock reacquire pulse so that the surrounding loops can return to acquisition.

Top module: `vsyncFieldDetector`

## Requirements
- R1: The low count is the number of samples with `sampleLow` high since the most recent `lineStart`. The samples need not be consecutive. The count clears on a `lineStart` clock, and the sample taken in that clock is not counted. The count saturates at its maximum instead of wrapping.
- R2: The condition for `vsync` is low count strictly greater than `threshold`. When that condition is met while `vsync` is low, `vsync` goes high on the very next clock. A count equal to the threshold does not raise it.
- R3: On a detected assertion, `field` is set from the crossing position, which is the number of clocks since `lineStart`. A position below LINE_SAMPLES/2 gives 0 (odd). A position at or above LINE_SAMPLES/2 gives 1 (even).
- R4: Once high, `vsync` stays high through at least VS_MIN_LINES further line starts. It falls on the first line start after that which closes a line containing no crossing.
- R5: While `vsync` is high, `field` does not change, even if more crossings occur.
- R6: With no crossing, a synthetic `vsync` assertion occurs on the N-th line start after the last assertion, and `field` toggles. N is the long field length (263 when `palMode`=0, 313 when `palMode`=1) if `field` is 0. N is the short length (262 or 312) if `field` is 1.
- R7: `reacquire` is a one-clock pulse. It fires on the line start that closes the 340th consecutive line without a crossing (LOSS_LINES + MISS_RUN). It fires only once per loss, and any crossing restarts the count.
- R8: After reset, `vsync`, `field` and `reacquire` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-clock strobe at each horizontal sync edge / line start |
| sampleLow | input | 1 | Current sample is at sync-tip level |
| threshold | input | LOW_W | Low-count detect threshold (strict greater-than) |
| palMode | input | 1 | 0 selects 525-line field lengths, 1 selects 625-line |
| vsync | output | 1 | Vertical sync output |
| field | output | 1 | 0 odd field, 1 even field |
| reacquire | output | 1 | One-clock pulse when vertical sync is declared lost |

## Verification
The bench builds the block with LINE_SAMPLES=32 and VS_MIN_LINES=2, and keeps the default line totals and loss limits. Short lines make the half-line boundary reachable within a few samples. The R3 decision can therefore be probed at positions 15 and 16. They also let a full 525-line flywheel cycle, the 340-line loss declaration and a 625-line short field all run in a few tens of thousands of clocks. A two-line minimum makes the hold rule of R4 observable apart from a plain one-line delay.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  // control -> datapath
  typedef struct packed {
    logic fwClear;    // restart flywheel line count (any vsync assertion)
    logic longField;  // next field uses the long nominal length
  } vfdStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic lowHit;      // low count above threshold in the current line
    logic lineHadHit;  // a crossing occurred somewhere in the line now ending
    logic lateHalf;    // current position is in the second half of the line
    logic fwDue;       // nominal field length reached at this line start
    logic lostDue;     // loss limit reached at this line start
  } vfdStatus_t;

endpackage

// File: rtl/vfdSatCounter.sv
module vfdSatCounter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  input  logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rstN)                      count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && count < limit)  count <= count + 1'b1;
  end

endmodule

// File: rtl/vfdDatapath.sv
module vfdDatapath
  import vfd_pkg::*;
#(
  parameter int LINE_SAMPLES = 858,
  parameter int LOW_W        = 8,
  parameter int NTSC_LINES   = 525,
  parameter int PAL_LINES    = 625,
  parameter int LOSS_LINES   = 337,
  parameter int MISS_RUN     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             sampleLow,
  input  logic [LOW_W-1:0] threshold,
  input  logic             palMode,
  input  vfdStrobe_t       strobe,
  output vfdStatus_t       status
);

  localparam int POS_W      = $clog2(LINE_SAMPLES + 1);
  localparam int HALF_POS   = LINE_SAMPLES / 2;
  localparam int NTSC_SHORT = NTSC_LINES / 2;
  localparam int NTSC_LONG  = NTSC_LINES - NTSC_SHORT;
  localparam int PAL_SHORT  = PAL_LINES / 2;
  localparam int PAL_LONG   = PAL_LINES - PAL_SHORT;
  localparam int LOST_AT    = LOSS_LINES + MISS_RUN;
  localparam int LCNT_MAX   = (PAL_LINES > LOST_AT) ? PAL_LINES : LOST_AT;
  localparam int LCNT_W     = $clog2(LCNT_MAX + 2);

  logic [LOW_W-1:0]  lowCnt;
  logic [POS_W-1:0]  posCnt;
  logic [LCNT_W-1:0] fwCnt;
  logic [LCNT_W-1:0] missCnt;
  logic [LCNT_W-1:0] fieldLen;
  logic              lineHit;

  // per-line low-sample accumulator
  vfdSatCounter #(.WIDTH(LOW_W)) uLowCnt (
    .clk(clk), .rstN(rstN), .clr(lineStart), .inc(sampleLow),
    .limit({LOW_W{1'b1}}), .count(lowCnt)
  );

  // sample position within the line
  vfdSatCounter #(.WIDTH(POS_W)) uPosCnt (
    .clk(clk), .rstN(rstN), .clr(lineStart), .inc(1'b1),
    .limit({POS_W{1'b1}}), .count(posCnt)
  );

  // lines since last vsync assertion (flywheel)
  vfdSatCounter #(.WIDTH(LCNT_W)) uFwCnt (
    .clk(clk), .rstN(rstN), .clr(strobe.fwClear), .inc(lineStart),
    .limit(fieldLen - 1'b1), .count(fwCnt)
  );

  // consecutive completed lines without a crossing
  vfdSatCounter #(.WIDTH(LCNT_W)) uMissCnt (
    .clk(clk), .rstN(rstN), .clr(lineStart && status.lineHadHit), .inc(lineStart),
    .limit(LCNT_W'(LOST_AT)), .count(missCnt)
  );

  always_comb begin
    case ({palMode, strobe.longField})
      2'b00:   fieldLen = LCNT_W'(NTSC_SHORT);
      2'b01:   fieldLen = LCNT_W'(NTSC_LONG);
      2'b10:   fieldLen = LCNT_W'(PAL_SHORT);
      default: fieldLen = LCNT_W'(PAL_LONG);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lineHit <= 1'b0;
    else if (lineStart) lineHit <= 1'b0;
    else if (status.lowHit) lineHit <= 1'b1;
  end

  always_comb begin
    status.lowHit     = lowCnt > threshold;
    status.lineHadHit = lineHit | status.lowHit;
    status.lateHalf   = posCnt >= POS_W'(HALF_POS);
    status.fwDue      = lineStart && (fwCnt >= fieldLen - 1'b1);
    status.lostDue    = lineStart && !status.lineHadHit && (missCnt == LCNT_W'(LOST_AT - 1));
  end

  // R1
  lowcnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (lowCnt == '0));

  // R1
  lowcnt_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> (lowCnt >= $past(lowCnt)));

endmodule

// File: rtl/vfdControl.sv
module vfdControl
  import vfd_pkg::*;
#(
  parameter int VS_MIN_LINES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStart,
  input  vfdStatus_t status,
  output vfdStrobe_t strobe,
  output logic       vsync,
  output logic       field,
  output logic       reacquire
);

  localparam int VSL_W = $clog2(VS_MIN_LINES + 2);

  logic [VSL_W-1:0] vsLines;
  logic             detect;
  logic             synth;

  always_comb begin
    detect           = status.lowHit && !vsync;
    synth            = status.fwDue && !vsync && !detect;
    strobe.fwClear   = detect || synth;
    strobe.longField = !field;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsync     <= 1'b0;
      field     <= 1'b0;
      vsLines   <= '0;
      reacquire <= 1'b0;
    end else begin
      reacquire <= status.lostDue;
      if (detect) begin
        vsync   <= 1'b1;
        field   <= status.lateHalf;
        vsLines <= '0;
      end else if (synth) begin
        vsync   <= 1'b1;
        field   <= !field;
        vsLines <= '0;
      end else if (vsync && lineStart) begin
        if (vsLines >= VSL_W'(VS_MIN_LINES)) begin
          if (!status.lineHadHit) vsync <= 1'b0;
        end else begin
          vsLines <= vsLines + 1'b1;
        end
      end
    end
  end

  // R2
  vsync_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsync) |-> ($past(status.lowHit) || $past(lineStart)));

  // R4
  vsync_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsync) |-> $past(lineStart));

  // R5
  field_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(vsync) |-> $stable(field));

  // R7
  reacq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reacquire |=> !reacquire);

  // R7
  reacq_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    reacquire |-> $past(lineStart));

endmodule

// File: rtl/vsyncFieldDetector.sv
module vsyncFieldDetector
  import vfd_pkg::*;
#(
  parameter int LINE_SAMPLES = 858,
  parameter int LOW_W        = 8,
  parameter int NTSC_LINES   = 525,
  parameter int PAL_LINES    = 625,
  parameter int LOSS_LINES   = 337,
  parameter int MISS_RUN     = 3,
  parameter int VS_MIN_LINES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             sampleLow,
  input  logic [LOW_W-1:0] threshold,
  input  logic             palMode,
  output logic             vsync,
  output logic             field,
  output logic             reacquire
);

  vfdStrobe_t strobe;
  vfdStatus_t status;

  vfdDatapath #(
    .LINE_SAMPLES(LINE_SAMPLES), .LOW_W(LOW_W), .NTSC_LINES(NTSC_LINES),
    .PAL_LINES(PAL_LINES), .LOSS_LINES(LOSS_LINES), .MISS_RUN(MISS_RUN)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .sampleLow(sampleLow),
    .threshold(threshold), .palMode(palMode), .strobe(strobe), .status(status)
  );

  vfdControl #(.VS_MIN_LINES(VS_MIN_LINES)) uControl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .status(status),
    .strobe(strobe), .vsync(vsync), .field(field), .reacquire(reacquire)
  );

endmodule

// File: tb/tb_vsyncFieldDetector.sv
module tb_vsyncFieldDetector;

  localparam int LINE  = 32;
  localparam int LOW_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             lineStart = 1'b0;
  logic             sampleLow = 1'b0;
  logic [LOW_W-1:0] threshold = 8'd5;
  logic             palMode = 1'b0;
  logic             vsync, field, reacquire;

  int checks = 0;
  int failures = 0;
  int reacqCount = 0;
  int reacqLong = 0;
  logic prevReacq = 1'b0;

  always #2 clk = ~clk;

  vsyncFieldDetector #(
    .LINE_SAMPLES(LINE), .LOW_W(LOW_W), .VS_MIN_LINES(2)
  ) dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .sampleLow(sampleLow),
    .threshold(threshold), .palMode(palMode),
    .vsync(vsync), .field(field), .reacquire(reacquire)
  );

  always @(negedge clk) begin
    if (reacquire) reacqCount++;
    if (reacquire && prevReacq) reacqLong++;
    prevReacq = reacquire;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // one line of LINE samples; low from lowStart for lowLen samples (lowLen may be 0)
  task automatic runLine(input int lowStart, input int lowLen);
    for (int i = 0; i < LINE; i++) begin
      lineStart = (i == 0);
      sampleLow = (i >= lowStart) && (i < lowStart + lowLen);
      @(negedge clk);
    end
    lineStart = 1'b0;
    sampleLow = 1'b0;
  endtask

  task automatic cleanLines(input int n);
    for (int k = 0; k < n; k++) runLine(0, 0);
  endtask

  // with VS_MIN_LINES=2 a single-crossing assertion drops at the third clean line start
  task automatic dropVsync();
    cleanLines(2);
    check("R4 hold two lines", vsync, 1);
    cleanLines(1);
    check("R4 fall after clean line", vsync, 0);
  endtask

  task automatic testReset();
    check("R8 vsync reset", vsync, 0);
    check("R8 field reset", field, 0);
    check("R8 reacquire reset", reacquire, 0);
  endtask

  task automatic testThreshold();
    runLine(1, 5);  // count equals threshold
    check("R2 equal to threshold no vsync", vsync, 0);
    // three lows, gap, three lows: total 6 > 5, crossing at position 12
    for (int i = 0; i < LINE; i++) begin
      lineStart = (i == 0);
      sampleLow = ((i >= 2) && (i <= 4)) || ((i >= 10) && (i <= 12));
      @(negedge clk);
    end
    check("R1 non-consecutive lows accumulate", vsync, 1);
    check("R3 early crossing odd", field, 0);
    dropVsync();
  endtask

  task automatic testRiseTiming();
    for (int i = 0; i < LINE; i++) begin
      lineStart = (i == 0);
      sampleLow = (i >= 1) && (i <= 6);
      @(negedge clk);
      if (i == 6) check("R2 not before the clock after crossing", vsync, 0);
      if (i == 7) check("R2 asserted on clock after crossing", vsync, 1);
    end
    check("R3 field odd", field, 0);
    dropVsync();
  endtask

  task automatic testFieldBoundary();
    runLine(11, 6);  // crossing at position 16
    check("R3 crossing at half line even", field, 1);
    dropVsync();
    runLine(10, 6);  // crossing at position 15
    check("R3 crossing just before half odd", field, 0);
    dropVsync();
    runLine(17, 10);
    check("R3 late crossing even", field, 1);
    dropVsync();
  endtask

  task automatic testHold();
    runLine(1, 8);
    check("R5 initial odd", field, 0);
    for (int k = 0; k < 4; k++) runLine(17, 10);
    check("R5 later crossings ignored for field", field, 0);
    check("R4 stays high while crossings continue", vsync, 1);
    cleanLines(1);
    check("R4 still high, last line had crossing", vsync, 1);
    check("R5 field unchanged", field, 0);
    cleanLines(1);
    check("R4 falls after first clean line", vsync, 0);
  endtask

  task automatic testFlywheelNtsc();
    palMode = 1'b0;
    runLine(1, 8);  // real odd detection, next field long (263)
    check("R3 odd before flywheel", field, 0);
    cleanLines(262);
    check("R6 no synthetic before 263 lines", vsync, 0);
    check("R6 field unchanged before 263", field, 0);
    cleanLines(1);
    check("R6 synthetic vsync at 263", vsync, 1);
    check("R6 field toggles to even", field, 1);
    cleanLines(340 - 263);
    check("R7 no reacquire after 340 clean lines", reacqCount, 0);
    cleanLines(1);
    check("R7 reacquire on 341st line start", reacqCount, 1);
    check("R7 single-clock pulse", reacqLong, 0);
    cleanLines(524 - 341);
    check("R6 no synthetic before short field ends", vsync, 0);
    cleanLines(1);
    check("R6 synthetic vsync after short field 262", vsync, 1);
    check("R6 field toggles back to odd", field, 0);
    check("R7 only one pulse per loss", reacqCount, 1);
    cleanLines(3);
    check("R4 synthetic pulse ends", vsync, 0);
  endtask

  task automatic testFlywheelPal();
    palMode = 1'b1;
    runLine(17, 10);  // real even detection, next field short (312)
    check("R3 even before flywheel", field, 1);
    cleanLines(311);
    check("R6 PAL no synthetic before 312", vsync, 0);
    cleanLines(1);
    check("R6 PAL synthetic vsync at 312", vsync, 1);
    check("R6 PAL field toggles to odd", field, 0);
    check("R7 crossing restarted loss count", reacqCount, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testThreshold();
    testRiseTiming();
    testFieldBoundary();
    testHold();
    testFlywheelNtsc();
    testFlywheelPal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule